// File: doc/BRIEF.md
# Out-of-Order Issue Scheduler with Pipe Selection

This block is the scheduling buffer between dispatch and a set of execution pipes. Each accepted instruction takes one slot and is then in one of three states. It is waiting while any source operand is still missing. It is ready once every operand is present. It is issued once it has been sent to a pipe and is not yet finished. Operand availability comes in through a destination-tag broadcast. An entry compares the broadcast tag with its own source tags, both while it waits and in the cycle it is being dispatched.

In each cycle the scheduler picks at most one ready entry, the oldest one that has at least one allowed pipe that is not busy, and sends it to a pipe. The pipe comes from the entry's allowed-pipe mask through a round-robin pointer. The pointer skips busy pipes and moves to the pipe after the one it granted. After the instruction's latency has run out, the entry reports write-back to the retire side and frees its slot.

The dispatch side is valid/ready. An item is taken in a cycle where `disp_valid` and `disp_ready` are both high. While `disp_ready` is low the sender must hold the item, and the scheduler ignores it. `disp_ready` is low only when every slot is occupied. The issue and write-back outputs are single-cycle strobes with no back-pressure. Pipes hold off issue through `pipe_busy` instead.

Top module: `oo_issue_sched`

## Requirements
- R1: After reset `disp_ready` is 1, and `iss_valid` and `wb_valid` are 0.
- R2: An item is accepted exactly when `disp_valid` and `disp_ready` are both 1. `disp_ready` is 0 exactly while all ENTRIES slots are occupied. An item offered while `disp_ready` is 0 is never issued.
- R3: A source counts as present at dispatch if its `disp_src_rdy` bit is 1 (bit k belongs to source k, and source k's tag is `disp_src_tag[k*TAGW +: TAGW]`) or if `wk_valid` broadcasts that tag in the same cycle. An item with all sources present can issue in the cycle after it is accepted, and never in the cycle it is accepted.
- R4: A waiting entry becomes issuable in the cycle after the broadcast that supplies its last missing source. Before that cycle it does not issue.
- R5: When several entries can issue, the one accepted earliest goes first, whatever slot it sits in.
- R6: On issue, `iss_pipe` has exactly one bit set. That bit is inside the entry's `disp_mask` and is not set in `pipe_busy`. An entry whose allowed pipes are all busy does not issue.
- R7: The pipe granted is the first allowed, non-busy pipe at or after the round-robin pointer, in ascending bit order with wrap-around. The pointer starts at pipe 0 and, after each grant, moves to the pipe after the one granted.
- R8: Write-back for an instruction issued in cycle t with latency L (L = 0 counts as 1) is reported with `wb_valid` and `wb_tag` no earlier than cycle t+L. At most one write-back is reported per cycle. If several entries are complete, the oldest is reported first and the others wait. The freed slot can be seen on `disp_ready` from the next cycle.
- R9: At most one instruction issues per cycle, and issue happens only while at least one slot is occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_valid | input | 1 | Dispatch item offered |
| disp_ready | output | 1 | A free slot exists; item taken when both are high |
| disp_tag | input | TAGW | Destination tag of the instruction |
| disp_src_tag | input | NSRC*TAGW | Source tags, source k in bits k*TAGW +: TAGW |
| disp_src_rdy | input | NSRC | Source k already available |
| disp_mask | input | NPIPES | Pipes the instruction may use, bit p is pipe p |
| disp_lat | input | LATW | Execution latency in cycles |
| wk_valid | input | 1 | Result broadcast this cycle |
| wk_tag | input | TAGW | Tag of the broadcast result |
| pipe_busy | input | NPIPES | Pipe p cannot accept an instruction this cycle |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_pipe | output | NPIPES | One-hot pipe receiving it |
| iss_tag | output | TAGW | Destination tag of the issued instruction |
| wb_valid | output | 1 | An instruction reaches write-back this cycle |
| wb_tag | output | TAGW | Tag handed to the retire side |

## Verification
Dispatch and wakeup can happen in the same cycle. The bench drives a consumer into the scheduler in the same cycle that the broadcast carries its last missing tag, and expects the issue in exactly the following cycle. A missed compare would show up as a hang or a late issue, and a forwarded compare as an issue in the dispatch cycle. Write-back completion is provoked in the same way: back-to-back issues with latencies 2 and 1 make two entries finish together. The scoreboard then expects the older one first and each later write-back to slip by exactly one cycle.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    SL_FREE   = 2'd0,
    SL_WAIT   = 2'd1,
    SL_READY  = 2'd2,
    SL_ISSUED = 2'd3
  } slot_state_e;
endpackage

// File: rtl/sched_slot.sv
module sched_slot import sched_pkg::*; #(
  parameter int NSRC   = 2,
  parameter int TAGW   = 6,
  parameter int NPIPES = 4,
  parameter int LATW   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc_i,
  input  logic [TAGW-1:0]        d_tag_i,
  input  logic [NSRC*TAGW-1:0]   d_src_tag_i,
  input  logic [NSRC-1:0]        d_src_rdy_i,
  input  logic [NPIPES-1:0]      d_mask_i,
  input  logic [LATW-1:0]        d_lat_i,
  input  logic                   wk_valid_i,
  input  logic [TAGW-1:0]        wk_tag_i,
  input  logic                   issue_i,
  input  logic                   wb_i,
  output slot_state_e            state_o,
  output logic [TAGW-1:0]        tag_o,
  output logic [NPIPES-1:0]      mask_o,
  output logic                   done_o
);
  slot_state_e           state_q;
  logic [NSRC*TAGW-1:0]  src_tag_q;
  logic [NSRC-1:0]       ok_q, hit_held, hit_new, ok_held, ok_new;
  logic [LATW-1:0]       lat_q, cnt_q;

  // tag compare for operands already held and for the incoming item
  always_comb begin
    for (int k = 0; k < NSRC; k++) begin
      hit_held[k] = wk_valid_i && (wk_tag_i == src_tag_q[k*TAGW +: TAGW]);
      hit_new[k]  = wk_valid_i && (wk_tag_i == d_src_tag_i[k*TAGW +: TAGW]);
    end
    ok_held = ok_q | hit_held;
    ok_new  = d_src_rdy_i | hit_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SL_FREE;
      ok_q    <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        SL_FREE: if (alloc_i) begin
          tag_o     <= d_tag_i;
          src_tag_q <= d_src_tag_i;
          mask_o    <= d_mask_i;
          lat_q     <= d_lat_i;
          ok_q      <= ok_new;
          state_q   <= (&ok_new) ? SL_READY : SL_WAIT;
        end
        SL_WAIT: begin
          ok_q <= ok_held;
          if (&ok_held) state_q <= SL_READY;
        end
        SL_READY: if (issue_i) begin
          state_q <= SL_ISSUED;
          cnt_q   <= (lat_q == '0) ? LATW'(1) : lat_q;
        end
        SL_ISSUED: begin
          if (wb_i)                     state_q <= SL_FREE;
          else if (cnt_q > LATW'(1))    cnt_q   <= cnt_q - LATW'(1);
        end
        default: state_q <= SL_FREE;
      endcase
    end
  end

  assign state_o = state_q;
  assign done_o  = (state_q == SL_ISSUED) && (cnt_q <= LATW'(1));
endmodule

// File: rtl/sched_age_track.sv
module sched_age_track #(
  parameter int N = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          alloc_i,
  output logic [N-1:0][N-1:0]   older_o
);
  // older_o[i][j] set: slot i was filled before slot j
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      older_o <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          if (alloc_i[i])                older_o[i][j] <= 1'b0;
          else if (alloc_i[j] && i != j) older_o[i][j] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sched_oldest_pick.sv
module sched_oldest_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0]          req_i,
  input  logic [N-1:0][N-1:0]   older_i,
  output logic [N-1:0]          grant_o
);
  for (genvar i = 0; i < N; i++) begin : g_col
    logic [N-1:0] beaten;
    always_comb begin
      for (int j = 0; j < N; j++) beaten[j] = req_i[j] && older_i[j][i];
    end
    assign grant_o[i] = req_i[i] && !(|beaten);
  end
endmodule

// File: rtl/sched_rr_pick.sv
module sched_rr_pick #(
  parameter int N = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  avail_i,
  output logic [N-1:0]  grant_o
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr_q, gidx;
  logic          found;

  always_comb begin
    int idx;
    grant_o = '0;
    gidx    = ptr_q;
    found   = 1'b0;
    for (int k = 0; k < N; k++) begin
      idx = int'(ptr_q) + k;
      if (idx >= N) idx = idx - N;
      if (!found && avail_i[idx]) begin
        found        = 1'b1;
        grant_o[idx] = 1'b1;
        gidx         = PW'(idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_q <= '0;
    else if (found) ptr_q <= (gidx == PW'(N-1)) ? '0 : gidx + PW'(1);
  end
endmodule

// File: rtl/oo_issue_sched.sv
module oo_issue_sched import sched_pkg::*; #(
  parameter int ENTRIES = 8,
  parameter int NPIPES  = 4,
  parameter int NSRC    = 2,
  parameter int TAGW    = 6,
  parameter int LATW    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  disp_valid,
  output logic                  disp_ready,
  input  logic [TAGW-1:0]       disp_tag,
  input  logic [NSRC*TAGW-1:0]  disp_src_tag,
  input  logic [NSRC-1:0]       disp_src_rdy,
  input  logic [NPIPES-1:0]     disp_mask,
  input  logic [LATW-1:0]       disp_lat,
  input  logic                  wk_valid,
  input  logic [TAGW-1:0]       wk_tag,
  input  logic [NPIPES-1:0]     pipe_busy,
  output logic                  iss_valid,
  output logic [NPIPES-1:0]     iss_pipe,
  output logic [TAGW-1:0]       iss_tag,
  output logic                  wb_valid,
  output logic [TAGW-1:0]       wb_tag
);
  slot_state_e                   st_a   [ENTRIES];
  logic [TAGW-1:0]               tag_a  [ENTRIES];
  logic [NPIPES-1:0]             mask_a [ENTRIES];
  logic [ENTRIES-1:0]            free_v, first_free, alloc, elig, done, igrant, wgrant;
  logic [ENTRIES-1:0][ENTRIES-1:0] older;
  logic [NPIPES-1:0]             win_mask;
  logic                          fire;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      free_v[i] = (st_a[i] == SL_FREE);
      elig[i]   = (st_a[i] == SL_READY) && (|(mask_a[i] & ~pipe_busy));
    end
  end

  assign disp_ready = |free_v;
  assign fire       = disp_valid && disp_ready;
  assign first_free = free_v & (~free_v + ENTRIES'(1));
  assign alloc      = fire ? first_free : '0;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    sched_slot #(.NSRC(NSRC), .TAGW(TAGW), .NPIPES(NPIPES), .LATW(LATW)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_i     (alloc[i]),
      .d_tag_i     (disp_tag),
      .d_src_tag_i (disp_src_tag),
      .d_src_rdy_i (disp_src_rdy),
      .d_mask_i    (disp_mask),
      .d_lat_i     (disp_lat),
      .wk_valid_i  (wk_valid),
      .wk_tag_i    (wk_tag),
      .issue_i     (igrant[i]),
      .wb_i        (wgrant[i]),
      .state_o     (st_a[i]),
      .tag_o       (tag_a[i]),
      .mask_o      (mask_a[i]),
      .done_o      (done[i])
    );
  end

  sched_age_track #(.N(ENTRIES)) u_age (
    .clk     (clk),
    .rst_n   (rst_n),
    .alloc_i (alloc),
    .older_o (older)
  );

  sched_oldest_pick #(.N(ENTRIES)) u_iss_pick (
    .req_i   (elig),
    .older_i (older),
    .grant_o (igrant)
  );

  sched_oldest_pick #(.N(ENTRIES)) u_wb_pick (
    .req_i   (done),
    .older_i (older),
    .grant_o (wgrant)
  );

  always_comb begin
    win_mask = '0;
    iss_tag  = '0;
    wb_tag   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (igrant[i]) begin
        win_mask = win_mask | mask_a[i];
        iss_tag  = iss_tag | tag_a[i];
      end
      if (wgrant[i]) wb_tag = wb_tag | tag_a[i];
    end
  end

  sched_rr_pick #(.N(NPIPES)) u_rr (
    .clk     (clk),
    .rst_n   (rst_n),
    .avail_i (win_mask & ~pipe_busy),
    .grant_o (iss_pipe)
  );

  assign iss_valid = |igrant;
  assign wb_valid  = |wgrant;
endmodule

// File: rtl/sched_checks.sv
module sched_checks #(
  parameter int ENTRIES = 8,
  parameter int NPIPES  = 4,
  parameter int TAGW    = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               disp_valid,
  input logic               disp_ready,
  input logic [TAGW-1:0]    disp_tag,
  input logic [NPIPES-1:0]  pipe_busy,
  input logic               iss_valid,
  input logic [NPIPES-1:0]  iss_pipe,
  input logic [TAGW-1:0]    iss_tag,
  input logic               wb_valid
);
  localparam int CW = $clog2(ENTRIES + 1);
  logic [CW-1:0] occ_q;
  logic          fire;
  assign fire = disp_valid && disp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else if (fire && !wb_valid) occ_q <= occ_q + CW'(1);
    else if (!fire && wb_valid) occ_q <= occ_q - CW'(1);
  end

  a_r2_ready_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
    disp_ready == (occ_q != CW'(ENTRIES)));
  a_r6_pipe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> ($countones(iss_pipe) == 1));
  a_r6_pipe_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> ((iss_pipe & pipe_busy) == '0));
  a_r9_quiet_pipe: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |-> (iss_pipe == '0));
  a_r3_issue_after_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !(iss_valid && iss_tag == disp_tag));
  a_r9_issue_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (occ_q != '0));
  a_r8_wb_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (occ_q != '0));
endmodule

bind oo_issue_sched sched_checks #(.ENTRIES(ENTRIES), .NPIPES(NPIPES), .TAGW(TAGW)) u_sched_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .disp_valid (disp_valid),
  .disp_ready (disp_ready),
  .disp_tag   (disp_tag),
  .pipe_busy  (pipe_busy),
  .iss_valid  (iss_valid),
  .iss_pipe   (iss_pipe),
  .iss_tag    (iss_tag),
  .wb_valid   (wb_valid)
);

// File: tb/test_oo_issue_sched.sv
`timescale 1ns/100ps
module test_oo_issue_sched;
  localparam int ENTRIES = 8, NPIPES = 4, NSRC = 2, TAGW = 6, LATW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic disp_valid = 1'b0, disp_ready;
  logic [TAGW-1:0] disp_tag = '0;
  logic [NSRC*TAGW-1:0] disp_src_tag = '0;
  logic [NSRC-1:0] disp_src_rdy = '0;
  logic [NPIPES-1:0] disp_mask = '0;
  logic [LATW-1:0] disp_lat = '0;
  logic wk_valid = 1'b0;
  logic [TAGW-1:0] wk_tag = '0;
  logic [NPIPES-1:0] pipe_busy = '0;
  logic iss_valid, wb_valid;
  logic [NPIPES-1:0] iss_pipe;
  logic [TAGW-1:0] iss_tag, wb_tag;

  int cyc = 0, n_chk = 0, n_bad = 0;
  bit finished = 1'b0;
  int eq_itag[$], eq_ipipe[$], eq_icyc[$], eq_wtag[$], eq_wcyc[$];
  string eq_ireq[$], eq_wreq[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  oo_issue_sched #(.ENTRIES(ENTRIES), .NPIPES(NPIPES), .NSRC(NSRC), .TAGW(TAGW), .LATW(LATW)) i_oo_issue_sched (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_tag(disp_tag), .disp_src_tag(disp_src_tag), .disp_src_rdy(disp_src_rdy),
    .disp_mask(disp_mask), .disp_lat(disp_lat), .wk_valid(wk_valid), .wk_tag(wk_tag),
    .pipe_busy(pipe_busy), .iss_valid(iss_valid), .iss_pipe(iss_pipe), .iss_tag(iss_tag),
    .wb_valid(wb_valid), .wb_tag(wb_tag)
  );

  task automatic check(input bit ok, input string req, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %s expected %s", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step();
  endtask

  task automatic expect_iss(input int tag, input int pipe, input int at, input string req);
    eq_itag.push_back(tag); eq_ipipe.push_back(pipe); eq_icyc.push_back(at); eq_ireq.push_back(req);
  endtask

  task automatic expect_wb(input int tag, input int at, input string req);
    eq_wtag.push_back(tag); eq_wcyc.push_back(at); eq_wreq.push_back(req);
  endtask

  task automatic offer(input int tag, input logic [1:0] rdy, input int s0, input int s1,
                       input logic [3:0] mask, input int lat);
    disp_valid   = 1'b1;
    disp_tag     = TAGW'(tag);
    disp_src_rdy = rdy;
    disp_src_tag = {TAGW'(s1), TAGW'(s0)};
    disp_mask    = mask;
    disp_lat     = LATW'(lat);
  endtask

  task automatic send(input int tag, input logic [1:0] rdy, input int s0, input int s1,
                      input logic [3:0] mask, input int lat);
    offer(tag, rdy, s0, s1, mask, lat);
    step();
    disp_valid = 1'b0;
  endtask

  // monitor: compares issue and write-back events against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (iss_valid) begin
        if (eq_itag.size() == 0)
          check(1'b0, "R2", $sformatf("issue tag %0d", iss_tag), "no issue");
        else begin
          int t, p, c;
          string r;
          t = eq_itag.pop_front(); p = eq_ipipe.pop_front(); c = eq_icyc.pop_front(); r = eq_ireq.pop_front();
          check(int'(iss_tag) == t && int'(iss_pipe) == p && cyc == c, r,
                $sformatf("tag %0d pipe %b cycle %0d", iss_tag, iss_pipe, cyc),
                $sformatf("tag %0d pipe %b cycle %0d", t, p[NPIPES-1:0], c));
        end
      end
      if (wb_valid) begin
        if (eq_wtag.size() == 0)
          check(1'b0, "R8", $sformatf("wb tag %0d", wb_tag), "no write-back");
        else begin
          int t, c;
          string r;
          t = eq_wtag.pop_front(); c = eq_wcyc.pop_front(); r = eq_wreq.pop_front();
          check(int'(wb_tag) == t && cyc == c, r,
                $sformatf("tag %0d cycle %0d", wb_tag, cyc),
                $sformatf("tag %0d cycle %0d", t, c));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(disp_ready == 1'b1 && !iss_valid && !wb_valid, "R1",
          $sformatf("ready %b iss %b wb %b", disp_ready, iss_valid, wb_valid), "ready 1 iss 0 wb 0");
    step();

    // back-to-back ready items, two pipes alternate, write-backs collide (R3 R7 R8)
    n = cyc;
    expect_iss(1, 4'b0001, n + 1, "R3");
    expect_iss(2, 4'b0010, n + 2, "R7");
    expect_iss(3, 4'b0001, n + 3, "R7");
    expect_iss(4, 4'b0010, n + 4, "R7");
    expect_wb(1, n + 3, "R8");
    expect_wb(2, n + 4, "R8");
    expect_wb(3, n + 5, "R8");
    expect_wb(4, n + 6, "R8");
    send(1, 2'b11, 0, 0, 4'b0011, 2);
    send(2, 2'b11, 0, 0, 4'b0011, 1);
    send(3, 2'b11, 0, 0, 4'b0011, 1);
    send(4, 2'b11, 0, 0, 4'b0011, 1);
    idle(6);

    // busy pipe at the pointer is skipped (R6 R7)
    n = cyc;
    pipe_busy = 4'b0100;
    expect_iss(5, 4'b1000, n + 1, "R6");
    expect_wb(5, n + 2, "R8");
    send(5, 2'b11, 0, 0, 4'b1111, 1);
    step();
    pipe_busy = '0;
    idle(3);

    // waiting on two tags, partial wakeup has no effect (R4)
    n = cyc;
    expect_iss(6, 4'b0001, n + 5, "R4");
    expect_wb(6, n + 6, "R8");
    send(6, 2'b00, 10, 11, 4'b0001, 1);
    idle(2);
    wk_valid = 1'b1; wk_tag = 10;
    step();
    wk_tag = 11;
    step();
    wk_valid = 1'b0;
    idle(4);

    // broadcast in the same cycle as dispatch (R3)
    n = cyc;
    expect_iss(7, 4'b0001, n + 1, "R3");
    expect_wb(7, n + 2, "R8");
    wk_valid = 1'b1; wk_tag = 12;
    send(7, 2'b01, 0, 12, 4'b0001, 1);
    wk_valid = 1'b0;
    idle(3);

    // older entry in a higher slot wins; all-busy blocks issue (R5 R6 R7)
    n = cyc;
    expect_iss(13, 4'b0100, n + 3, "R7");
    expect_wb(13, n + 4, "R8");
    expect_iss(8, 4'b0010, n + 9, "R5");
    expect_wb(8, n + 10, "R8");
    expect_iss(9, 4'b0010, n + 10, "R5");
    expect_wb(9, n + 11, "R8");
    send(13, 2'b00, 30, 30, 4'b0100, 1);
    send(8, 2'b00, 20, 20, 4'b0010, 1);
    wk_valid = 1'b1; wk_tag = 30;
    step();
    wk_valid = 1'b0;
    idle(2);
    send(9, 2'b00, 20, 20, 4'b0010, 1);
    idle(1);
    wk_valid = 1'b1; wk_tag = 20;
    step();
    wk_valid = 1'b0;
    pipe_busy = 4'b0010;
    @(negedge clk);
    check(!iss_valid, "R6", $sformatf("iss %b", iss_valid), "iss 0 while allowed pipe busy");
    step();
    pipe_busy = '0;
    idle(5);

    // fill every slot, refused offer, drain oldest-first (R2 R5 R8 R9)
    n = cyc;
    for (int k = 0; k < ENTRIES; k++) begin
      expect_iss(32 + k, 1 << ((2 + k) % NPIPES), n + 10 + k, "R9");
      expect_wb(32 + k, n + 11 + k, "R8");
    end
    for (int k = 0; k < ENTRIES; k++) begin
      offer(32 + k, 2'b00, 40, 40, 4'b1111, 1);
      @(negedge clk);
      check(disp_ready == 1'b1, "R2", $sformatf("ready %b", disp_ready), "ready 1 with free slot");
      step();
    end
    offer(50, 2'b11, 0, 0, 4'b1111, 1);
    @(negedge clk);
    check(disp_ready == 1'b0, "R2", $sformatf("ready %b", disp_ready), "ready 0 when full");
    step();
    disp_valid = 1'b0;
    wk_valid = 1'b1; wk_tag = 40;
    step();
    wk_valid = 1'b0;
    step();
    @(negedge clk);
    check(disp_ready == 1'b0, "R8", $sformatf("ready %b", disp_ready), "ready 0 in first write-back cycle");
    step();
    @(negedge clk);
    check(disp_ready == 1'b1, "R8", $sformatf("ready %b", disp_ready), "ready 1 after first write-back");
    idle(12);

    check(eq_itag.size() == 0 && eq_wtag.size() == 0, "R2",
          $sformatf("%0d issues %0d wbs pending", eq_itag.size(), eq_wtag.size()), "0 pending");
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule